// File: doc/BRIEF.md
# Machine CSR Write Legalization Slice

This block holds a small group of machine-level control and status registers. It enforces the write-any-read-legal rules for each of them. Software accesses it through a plain CSR port: a 12-bit address, write data and a write enable. Read data and an illegal-access flag come back combinationally from the registered state.

The slice covers five things:
- the counter-inhibit mask;
- a parameterised bank of performance-event selectors;
- the previous-privilege field of the machine status register;
- the privilege field of the debug control register;
- a constant ISA description register.

A write reaches storage at the next rising clock edge only when the address is legal. Any field that the configuration does not back reads as zero.

The parameter `N_HPM` sets how many hardware performance counters exist, starting at counter index 3. The parameter `EVT_W` sets the width of an event selector. The parameter `BITMANIP_X` states whether non-ratified bit-manipulation extensions are built into the core.

Top module: `csr_warl_slice`

## Requirements
- R1: The counter-inhibit register (0x320) resets to 0. Bits 0, 2 and 3 to 2+N_HPM store written values. Bit 1 and every bit above 2+N_HPM always read 0.
- R2: Event-selector addresses 0x323 to 0x322+N_HPM are legal. Selector index i resets to the one-hot value 1 << (i-3).
- R3: A write to a legal event selector stores the low EVT_W bits of the write data. The upper bits read 0.
- R4: Addresses 0x321, 0x322 and 0x323+N_HPM to 0x33F raise the illegal flag and read 0. Writes to them change no other register.
- R5: The status register (0x300) keeps only the previous-privilege field in bits 12:11. That field resets to 2'b11 and all other bits read 0.
- R6: A status write whose bits 12:11 are 2'b01 or 2'b10 stores 2'b00 (user). The values 2'b00 and 2'b11 are stored as written.
- R7: The debug control register (0x7B0) keeps only a privilege field in bits 1:0. It resets to 2'b11, follows the same fallback to 2'b00 for 2'b01 and 2'b10, and its other bits read 0.
- R8: The ISA register (0x301) reads 2'b01 in bits 31:30 and has bits 2, 8, 12 and 20 set. Bit 1 always reads 0.
- R9: ISA bit 23 equals BITMANIP_X, and writes to the ISA register have no effect.
- R10: Any address not listed above raises the illegal flag and reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| csr_addr_i | input | 12 | CSR address |
| csr_wdata_i | input | 32 | Write data |
| csr_we_i | input | 1 | Write enable, applied at the next rising edge |
| csr_rdata_o | output | 32 | Legalized read data for csr_addr_i |
| csr_illegal_o | output | 1 | Address is not implemented |

## Verification
The assertions take for granted that the address, write data and write enable settle after a rising edge and hold until the next one. The read-side properties compare the output against the address seen at that same edge. The fallback properties assume that the cycle after a privilege write either reads another address or reads the same field back.

The stimulus moves every input shortly after a rising edge and never changes an input mid-cycle. After a write it always spends at least one cycle before another access, so each stored value is read back once it has settled.

// File: rtl/csr_warl_pkg.sv
package csr_warl_pkg;

    localparam int XLEN = 32;

    localparam logic [11:0] ADDR_MSTATUS  = 12'h300;
    localparam logic [11:0] ADDR_MISA     = 12'h301;
    localparam logic [11:0] ADDR_CNT_BLK  = 12'h320;
    localparam logic [11:0] ADDR_DCSR     = 12'h7B0;

    localparam int EVT_FIRST  = 3;
    localparam int MPP_LO     = 11;
    localparam int DPRV_LO    = 0;
    localparam int ISA_B_BIT  = 1;
    localparam int ISA_X_BIT  = 23;

    // MXL=1 (32-bit), C, I, M, U
    localparam logic [XLEN-1:0] ISA_BASE = 32'h4010_1104;

    typedef logic [1:0] priv_t;
    localparam priv_t PRIV_USER = 2'b00;
    localparam priv_t PRIV_MACH = 2'b11;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_STATUS,
        SEL_ISA,
        SEL_INHIBIT,
        SEL_EVENT,
        SEL_DEBUG
    } csr_sel_e;

    function automatic priv_t legalize_priv(input priv_t req);
        return (req == PRIV_MACH) ? PRIV_MACH : PRIV_USER;
    endfunction

endpackage

// File: rtl/csr_addr_decode.sv
module csr_addr_decode
    import csr_warl_pkg::*;
#(
    parameter int N_HPM = 4
) (
    input  logic [11:0] addr_i,
    output csr_sel_e    sel_o,
    output logic [4:0]  evt_idx_o,
    output logic        illegal_o
);

    localparam int EVT_LAST = EVT_FIRST + N_HPM - 1;

    always_comb begin
        sel_o     = SEL_NONE;
        evt_idx_o = addr_i[4:0];
        if (addr_i == ADDR_MSTATUS) begin
            sel_o = SEL_STATUS;
        end else if (addr_i == ADDR_MISA) begin
            sel_o = SEL_ISA;
        end else if (addr_i == ADDR_DCSR) begin
            sel_o = SEL_DEBUG;
        end else if (addr_i[11:5] == ADDR_CNT_BLK[11:5]) begin
            if (addr_i[4:0] == 5'd0) begin
                sel_o = SEL_INHIBIT;
            end else if (int'(addr_i[4:0]) >= EVT_FIRST &&
                         int'(addr_i[4:0]) <= EVT_LAST) begin
                sel_o = SEL_EVENT;
            end
        end
    end

    assign illegal_o = (sel_o == SEL_NONE);

endmodule

// File: rtl/csr_event_bank.sv
module csr_event_bank
    import csr_warl_pkg::*;
#(
    parameter int N_HPM = 4,
    parameter int EVT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             we_i,
    input  logic [4:0]       idx_i,
    input  logic [EVT_W-1:0] wdata_i,
    output logic [XLEN-1:0]  rdata_o
);

    typedef struct packed {
        logic [N_HPM-1:0][EVT_W-1:0] sel;
    } evt_state_t;

    evt_state_t st_d, st_q;
    logic [N_HPM-1:0][EVT_W-1:0] rst_val;

    for (genvar g = 0; g < N_HPM; g++) begin : g_rst
        assign rst_val[g] = EVT_W'(1) << g;
    end

    always_comb begin
        st_d    = st_q;
        rdata_o = '0;
        for (int i = 0; i < N_HPM; i++) begin
            if (int'(idx_i) == i + EVT_FIRST) begin
                rdata_o = XLEN'(st_q.sel[i]);
                if (we_i) begin
                    st_d.sel[i] = wdata_i;
                end
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.sel <= rst_val;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/csr_warl_regs.sv
module csr_warl_regs
    import csr_warl_pkg::*;
#(
    parameter int N_HPM = 4
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            we_i,
    input  csr_sel_e        sel_i,
    input  logic [XLEN-1:0] wdata_i,
    output logic [XLEN-1:0] inhibit_o,
    output priv_t           mpp_o,
    output priv_t           dprv_o
);

    localparam logic [63:0] SPAN     = (64'(1) << (EVT_FIRST + N_HPM)) - 64'(1);
    localparam logic [XLEN-1:0] INH_MASK = SPAN[XLEN-1:0] & ~XLEN'(2);

    typedef struct packed {
        logic [XLEN-1:0] inhibit;
        priv_t           mpp;
        priv_t           dprv;
    } reg_state_t;

    reg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we_i) begin
            unique case (sel_i)
                SEL_INHIBIT: st_d.inhibit = wdata_i & INH_MASK;
                SEL_STATUS:  st_d.mpp     = legalize_priv(wdata_i[MPP_LO+:2]);
                SEL_DEBUG:   st_d.dprv    = legalize_priv(wdata_i[DPRV_LO+:2]);
                default:     ;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.inhibit <= '0;
            st_q.mpp     <= PRIV_MACH;
            st_q.dprv    <= PRIV_MACH;
        end else begin
            st_q <= st_d;
        end
    end

    assign inhibit_o = st_q.inhibit;
    assign mpp_o     = st_q.mpp;
    assign dprv_o    = st_q.dprv;

endmodule

// File: rtl/csr_warl_slice.sv
module csr_warl_slice
    import csr_warl_pkg::*;
#(
    parameter int   N_HPM      = 4,
    parameter int   EVT_W      = 16,
    parameter logic BITMANIP_X = 1'b1
) (
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic [11:0] csr_addr_i,
    input  logic [31:0] csr_wdata_i,
    input  logic        csr_we_i,
    output logic [31:0] csr_rdata_o,
    output logic        csr_illegal_o
);

    localparam logic [XLEN-1:0] ISA_VAL =
        (ISA_BASE | (XLEN'(BITMANIP_X) << ISA_X_BIT)) & ~(XLEN'(1) << ISA_B_BIT);

    csr_sel_e        sel;
    logic [4:0]      evt_idx;
    logic            illegal;
    logic            wr_ok;
    logic [XLEN-1:0] evt_rdata;
    logic [XLEN-1:0] inhibit;
    priv_t           mpp;
    priv_t           dprv;

    csr_addr_decode #(.N_HPM(N_HPM)) u_dec (
        .addr_i    (csr_addr_i),
        .sel_o     (sel),
        .evt_idx_o (evt_idx),
        .illegal_o (illegal)
    );

    assign wr_ok = csr_we_i & ~illegal;

    csr_event_bank #(.N_HPM(N_HPM), .EVT_W(EVT_W)) u_evt (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .we_i    (wr_ok && sel == SEL_EVENT),
        .idx_i   (evt_idx),
        .wdata_i (csr_wdata_i[EVT_W-1:0]),
        .rdata_o (evt_rdata)
    );

    csr_warl_regs #(.N_HPM(N_HPM)) u_regs (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .we_i      (wr_ok),
        .sel_i     (sel),
        .wdata_i   (csr_wdata_i),
        .inhibit_o (inhibit),
        .mpp_o     (mpp),
        .dprv_o    (dprv)
    );

    always_comb begin
        unique case (sel)
            SEL_STATUS:  csr_rdata_o = XLEN'(mpp) << MPP_LO;
            SEL_ISA:     csr_rdata_o = ISA_VAL;
            SEL_DEBUG:   csr_rdata_o = XLEN'(dprv) << DPRV_LO;
            SEL_INHIBIT: csr_rdata_o = inhibit;
            SEL_EVENT:   csr_rdata_o = evt_rdata;
            default:     csr_rdata_o = '0;
        endcase
    end

    assign csr_illegal_o = illegal;

endmodule

// File: rtl/csr_warl_checker.sv
module csr_warl_checker #(
    parameter int   N_HPM      = 4,
    parameter logic BITMANIP_X = 1'b1
) (
    input logic        clk_i,
    input logic        rst_ni,
    input logic [11:0] csr_addr_i,
    input logic [1:0]  mpp_wr_i,
    input logic [1:0]  dprv_wr_i,
    input logic        csr_we_i,
    input logic [31:0] csr_rdata_o,
    input logic        csr_illegal_o
);

    localparam logic [63:0] SPAN = (64'(1) << (3 + N_HPM)) - 64'(1);
    localparam logic [31:0] KEEP = SPAN[31:0] & ~32'd2;

    // R1
    inhibit_fixed_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (csr_addr_i == 12'h320) |-> ((csr_rdata_o & ~KEEP) == 32'd0));

    // R4
    low_event_illegal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (csr_addr_i == 12'h321 || csr_addr_i == 12'h322) |-> (csr_illegal_o && csr_rdata_o == 32'd0));

    // R5
    mpp_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (csr_addr_i == 12'h300) |-> ((csr_rdata_o[12:11] == 2'b00 || csr_rdata_o[12:11] == 2'b11)
                                     && (csr_rdata_o & ~32'h1800) == 32'd0));

    // R6
    mpp_fallback_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (csr_we_i && csr_addr_i == 12'h300 && (mpp_wr_i == 2'b01 || mpp_wr_i == 2'b10))
        |=> (csr_addr_i != 12'h300 || csr_rdata_o[12:11] == 2'b00));

    // R7
    dprv_fallback_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (csr_we_i && csr_addr_i == 12'h7B0 && (dprv_wr_i == 2'b01 || dprv_wr_i == 2'b10))
        |=> (csr_addr_i != 12'h7B0 || csr_rdata_o[1:0] == 2'b00));

    // R8
    isa_b_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (csr_addr_i == 12'h301) |-> (csr_rdata_o[1] == 1'b0 && csr_rdata_o[31:30] == 2'b01));

    // R9
    isa_x_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (csr_addr_i == 12'h301) |-> (csr_rdata_o[23] == BITMANIP_X));

    // R9
    isa_constant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (csr_addr_i == 12'h301 && $past(csr_addr_i) == 12'h301) |-> $stable(csr_rdata_o));

    // R10
    illegal_reads_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        csr_illegal_o |-> (csr_rdata_o == 32'd0));

endmodule

bind csr_warl_slice csr_warl_checker #(.N_HPM(N_HPM), .BITMANIP_X(BITMANIP_X)) chk_i (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .csr_addr_i    (csr_addr_i),
    .mpp_wr_i      (csr_wdata_i[12:11]),
    .dprv_wr_i     (csr_wdata_i[1:0]),
    .csr_we_i      (csr_we_i),
    .csr_rdata_o   (csr_rdata_o),
    .csr_illegal_o (csr_illegal_o)
);

// File: tb/csr_warl_slice_tb_top.sv
`timescale 1ns/1ps
module csr_warl_slice_tb_top;

    localparam int N_HPM = 4;
    localparam int EVT_W = 16;

    typedef struct packed {
        logic [11:0] addr;
        logic [31:0] data;
        logic        ill;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic        we = 1'b0;
    logic [31:0] rdata;
    logic        illegal;

    int vectors = 0;
    int fails = 0;
    bit done = 1'b0;

    item_t exp_q[$];
    string req_q[$];

    logic [31:0] m_inh;
    logic [1:0]  m_mpp, m_dprv;
    logic [EVT_W-1:0] m_evt [N_HPM];

    always #2.5 clk = ~clk;

    csr_warl_slice #(.N_HPM(N_HPM), .EVT_W(EVT_W), .BITMANIP_X(1'b1)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .csr_addr_i(addr), .csr_wdata_i(wdata),
        .csr_we_i(we), .csr_rdata_o(rdata), .csr_illegal_o(illegal)
    );

    function automatic bit evt_addr(input logic [11:0] a);
        return a >= 12'h323 && a < 12'(12'h323 + N_HPM);
    endfunction

    function automatic item_t model_read(input logic [11:0] a);
        item_t it;
        it.addr = a;
        it.ill  = 1'b0;
        it.data = '0;
        if (a == 12'h300)      it.data = {19'd0, m_mpp, 11'd0};
        else if (a == 12'h301) it.data = 32'h4090_1104;
        else if (a == 12'h7B0) it.data = {30'd0, m_dprv};
        else if (a == 12'h320) it.data = m_inh;
        else if (evt_addr(a))  it.data = 32'(m_evt[a - 12'h323]);
        else                   it.ill  = 1'b1;
        return it;
    endfunction

    function automatic logic [1:0] fold_priv(input logic [1:0] p);
        return (p == 2'b00 || p == 2'b11) ? p : 2'b00;
    endfunction

    task automatic model_write(input logic [11:0] a, input logic [31:0] d);
        if (a == 12'h300) m_mpp = fold_priv(d[12:11]);
        else if (a == 12'h7B0) m_dprv = fold_priv(d[1:0]);
        else if (a == 12'h320) begin
            for (int i = 0; i < 32; i++)
                m_inh[i] = (i == 0 || i == 2 || (i >= 3 && i < 3 + N_HPM)) ? d[i] : 1'b0;
        end else if (evt_addr(a)) m_evt[a - 12'h323] = d[EVT_W-1:0];
    endtask

    task automatic rd(input logic [11:0] a, input string r);
        @(posedge clk); #1;
        addr = a; we = 1'b0;
        exp_q.push_back(model_read(a));
        req_q.push_back(r);
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d, input string r);
        @(posedge clk); #1;
        addr = a; wdata = d; we = 1'b1;
        exp_q.push_back(model_read(a));
        req_q.push_back(r);
        model_write(a, d);
    endtask

    task automatic wr_rd(input logic [11:0] a, input logic [31:0] d, input string r);
        wr(a, d, r);
        rd(a, r);
    endtask

    initial begin : monitor
        forever begin
            @(negedge clk);
            while (exp_q.size() > 0) begin
                item_t it;
                string r;
                it = exp_q.pop_front();
                r  = req_q.pop_front();
                vectors++;
                if (rdata !== it.data || illegal !== it.ill) begin
                    fails++;
                    $display("FAIL %s addr=%h rdata=%h exp=%h illegal=%b exp=%b",
                             r, it.addr, rdata, it.data, illegal, it.ill);
                end
            end
        end
    end

    task automatic report;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    initial begin : watchdog
        #(200000 * 5);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            report();
        end
    end

    initial begin : driver
        m_inh = '0; m_mpp = 2'b11; m_dprv = 2'b11;
        for (int i = 0; i < N_HPM; i++) m_evt[i] = EVT_W'(1) << i;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // reset state
        rd(12'h320, "R1");
        for (int i = 0; i < N_HPM; i++) rd(12'(12'h323 + i), "R2");
        rd(12'h300, "R5");
        rd(12'h7B0, "R7");
        rd(12'h301, "R8");

        // R1 inhibit legalization
        wr_rd(12'h320, 32'hFFFF_FFFF, "R1");
        wr_rd(12'h320, 32'h0000_0002, "R1");
        wr_rd(12'h320, 32'h0000_0045, "R1");

        // R3 event writes
        wr_rd(12'h324, 32'hABCD_1234, "R3");
        wr_rd(12'h326, 32'hFFFF_FFFF, "R3");
        rd(12'h323, "R3");

        // R4 missing selectors, writes ignored
        wr_rd(12'h321, 32'hFFFF_FFFF, "R4");
        wr_rd(12'h322, 32'h0000_0001, "R4");
        wr_rd(12'(12'h323 + N_HPM), 32'h0000_5555, "R4");
        rd(12'h33F, "R4");
        rd(12'h320, "R4");
        for (int i = 0; i < N_HPM; i++) rd(12'(12'h323 + i), "R4");

        // R5 / R6 status previous privilege
        wr_rd(12'h300, 32'h0000_0800, "R6");
        wr_rd(12'h300, 32'h0000_1800, "R6");
        wr_rd(12'h300, 32'h0000_1000, "R6");
        wr_rd(12'h300, 32'hFFFF_E7FF, "R5");
        wr_rd(12'h300, 32'hFFFF_FFFF, "R5");

        // R7 debug privilege
        wr_rd(12'h7B0, 32'h0000_0001, "R7");
        wr_rd(12'h7B0, 32'h0000_0003, "R7");
        wr_rd(12'h7B0, 32'h0000_0002, "R7");
        wr_rd(12'h7B0, 32'hFFFF_FFFC, "R7");

        // R9 ISA writes ignored
        wr_rd(12'h301, 32'h0000_0000, "R9");
        wr_rd(12'h301, 32'hFFFF_FFFF, "R9");

        // R10 unknown addresses
        rd(12'h000, "R10");
        rd(12'h305, "R10");
        rd(12'h7B1, "R10");
        wr_rd(12'hFFF, 32'hFFFF_FFFF, "R10");
        rd(12'h300, "R10");

        @(posedge clk); #1 we = 1'b0;
        repeat (3) @(posedge clk);
        done = 1'b1;
        report();
    end

endmodule